// File: doc/BRIEF.md
# Two-stage watchdog timer

This block is a watchdog timer run by one 32-bit control word. Software writes the word through a plain write port and can read it back at any time. A reference tick enable is divided by a selectable prescaler. Each prescaled tick advances an up-counter. When the counter reaches the selected interval, the block sets an interrupt flag, and it drives the interrupt line if interrupts are allowed. The counter then starts a fixed grace period. If software does not restart the count before the grace period ends, and reset requests are allowed, the block emits a one-cycle reset request and marks that the watchdog caused it.

The system answers the request by pulsing the watchdog reset input. That input returns the control word to its default value but leaves the reset-cause flag set, so that software can see after reboot why the system restarted. The power-on reset clears everything. Software pauses the count by clearing the enable bit and resumes it by setting the bit again. The register port has no handshake: a write is taken on every clock edge where `wr_en` is high, and `rd_data` always shows the current word. Nothing can be held off, so the port has no back-pressure.

Bit map of the control word (other bits read 0 and ignore writes): [11:10] prescale select, [7] count enable, [6] interrupt enable, [5:4] interval select, [3] interrupt flag, [2] reset-cause flag, [1] reset-request enable, [0] restart command.

Top module: `wdt_timer`

## Requirements
- R1: After power-on reset, `rd_data` reads 32'h0000_0400 (prescale select = 1, every other bit 0), and `irq` and `rst_req` are low.
- R2: Writing 1 to bit 0 clears the tick counter and the prescaler phase and cancels a running grace period, so that counting starts over from zero. Bit 0 always reads 0.
- R3: Prescale select values 0, 1, 2 and 3 divide the reference ticks by 2^PRESC_LOG2[0..3] (by default 1, 256, 2048 and 65536).
- R4: With enable set and `tick_en` held high from the write edge on, the interrupt flag (bit 3) is still clear TMO*DIV-1 cycles after the write and is set exactly TMO*DIV cycles after it. Here TMO = 2^(BASE_LOG2 + STEP_LOG2*interval select) and DIV is the divisor from R3.
- R5: The interrupt flag is set at timeout even when interrupt enable (bit 6) is clear. `irq` equals flag AND interrupt enable at all times.
- R6: When reset-request enable (bit 1) is set, `rst_req` is high for exactly one cycle, DELAY_TICKS prescaled ticks after the timeout, whatever the value of interrupt enable. The reset-cause flag (bit 2) is set in the same cycle.
- R7: When reset-request enable is clear, `rst_req` stays low and the reset-cause flag stays clear after the grace period has elapsed.
- R8: Writing 1 to bit 3 or bit 2 clears that flag. Writing 0 to them leaves them unchanged.
- R9: A low `rst_wdt_n` returns the word to its default value while keeping the reset-cause flag. A low `rst_por_n` clears the reset-cause flag too.
- R10: Clearing enable freezes the count. Setting enable again resumes from the frozen value, so expiry comes after only the remaining ticks.
- R11: Only cycles with `tick_en` high advance the prescaler. Cycles with `tick_en` low delay the expiry by exactly their number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_por_n | input | 1 | Power-on reset, active low, synchronous; clears all state |
| rst_wdt_n | input | 1 | Watchdog-caused reset, active low, synchronous; keeps the reset-cause flag |
| tick_en | input | 1 | Reference tick enable; the prescaler counts cycles where this is high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Current control word |
| irq | output | 1 | Interrupt request level |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the timer with BASE_LOG2 = 4, STEP_LOG2 = 1, DELAY_TICKS = 8 and prescale exponents 0, 1, 2 and 3. With these values every interval takes 16 to 128 ticks and every divisor is 1 to 8. All sixteen combinations of prescale and interval select can then be checked at their exact expiry cycle, which the default sizes would place up to 2^36 cycles away. The short grace period makes the reset pulse, its gating, the pause, the `tick_en` gaps and the cancel-by-restart cases reachable within a few dozen cycles each.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned SEL_N      = 1 << SEL_W;

  // bit positions of the control word (software decodes these)
  localparam int unsigned POS_PSEL   = 10;
  localparam int unsigned POS_EN     = 7;
  localparam int unsigned POS_IE     = 6;
  localparam int unsigned POS_ISEL   = 4;
  localparam int unsigned POS_IFLAG  = 3;
  localparam int unsigned POS_RFLAG  = 2;
  localparam int unsigned POS_RE     = 1;
  localparam int unsigned POS_RSTART = 0;

  localparam logic [SEL_W-1:0] PSEL_DEFAULT = SEL_W'(1);

  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_GRACE = 2'd1,
    ST_DONE  = 2'd2
  } wdt_stage_e;

  typedef struct packed {
    logic [SEL_W-1:0] psel;
    logic             en;
    logic             ie;
    logic [SEL_W-1:0] isel;
    logic             re;
  } wdt_cfg_t;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int unsigned PRESC_LOG2 [SEL_N] = '{0, 8, 11, 16}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick_en,
  input  logic             restart,
  input  logic [SEL_W-1:0] psel,
  output logic             presc_tick
);

  function automatic int unsigned widest();
    int unsigned m = 1;
    for (int i = 0; i < SEL_N; i++) begin
      if (PRESC_LOG2[i] > m) m = PRESC_LOG2[i];
    end
    return m;
  endfunction

  localparam int unsigned PH_W = widest();

  logic [PH_W-1:0] wrap_at [SEL_N];
  logic [PH_W-1:0] phase;

  for (genvar g = 0; g < SEL_N; g++) begin : g_wrap
    assign wrap_at[g] = PH_W'((64'(1) << PRESC_LOG2[g]) - 64'(1));
  end

  assign presc_tick = run && tick_en && !restart && (phase >= wrap_at[psel]);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase <= '0;
    end else if (run && tick_en) begin
      phase <= presc_tick ? '0 : phase + PH_W'(1);
    end
  end

  AST_TICK_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
    presc_tick |-> (tick_en && run)) else $error("prescaled tick without reference tick"); // R11

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase == '0)) else $error("restart left prescaler phase"); // R2

  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(phase)) else $error("phase moved while paused"); // R10

endmodule

// File: rtl/wdt_interval_cnt.sv
module wdt_interval_cnt
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2   = 14,
  parameter int unsigned STEP_LOG2   = 2,
  parameter int unsigned DELAY_TICKS = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [SEL_W-1:0] isel,
  output logic             expire,
  output logic             grace_done
);

  localparam int unsigned TOP_LOG2 = BASE_LOG2 + STEP_LOG2 * (SEL_N - 1);
  localparam int unsigned DLY_W    = $clog2(DELAY_TICKS + 1);
  localparam int unsigned CNT_W    = (TOP_LOG2 + 1 > DLY_W) ? TOP_LOG2 + 1 : DLY_W;

  logic [CNT_W-1:0] limit [SEL_N];
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] count_inc;
  wdt_stage_e       stage;

  for (genvar g = 0; g < SEL_N; g++) begin : g_limit
    assign limit[g] = CNT_W'(64'(1) << (BASE_LOG2 + STEP_LOG2 * g));
  end

  assign count_inc  = count + CNT_W'(1);
  assign expire     = tick && !restart && (stage == ST_COUNT) && (count_inc >= limit[isel]);
  assign grace_done = tick && !restart && (stage == ST_GRACE) &&
                      (count_inc >= CNT_W'(DELAY_TICKS));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      count <= '0;
      stage <= ST_COUNT;
    end else if (tick) begin
      unique case (stage)
        ST_COUNT: begin
          if (expire) begin
            count <= '0;
            stage <= ST_GRACE;
          end else begin
            count <= count_inc;
          end
        end
        ST_GRACE: begin
          if (grace_done) begin
            count <= '0;
            stage <= ST_DONE;
          end else begin
            count <= count_inc;
          end
        end
        default: begin
          count <= count;
          stage <= ST_DONE;
        end
      endcase
    end
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (count == '0 && stage == ST_COUNT)) else $error("restart did not clear count"); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> ($stable(count) && $stable(stage))) else $error("count moved without tick"); // R10

  AST_EXPIRE_ONCE: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire) else $error("timeout fired twice in a row"); // R4

  AST_GRACE_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (rst)
    grace_done |-> (stage == ST_GRACE)) else $error("grace end outside grace period"); // R6

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             por_rst,
  input  logic             any_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             expire,
  input  logic             grace_done,
  output wdt_cfg_t         cfg,
  output logic             iflag,
  output logic             restart,
  output logic             rst_req,
  output logic [REG_W-1:0] rd_data
);

  logic rflag;
  logic unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[REG_W-1:POS_PSEL+SEL_W], wr_data[POS_PSEL-1:POS_EN+1]};
  assign restart = wr_en && wr_data[POS_RSTART];

  always_ff @(posedge clk) begin
    if (any_rst) begin
      cfg <= '{psel: PSEL_DEFAULT, en: 1'b0, ie: 1'b0, isel: '0, re: 1'b0};
    end else if (wr_en) begin
      cfg.psel <= wr_data[POS_PSEL +: SEL_W];
      cfg.en   <= wr_data[POS_EN];
      cfg.ie   <= wr_data[POS_IE];
      cfg.isel <= wr_data[POS_ISEL +: SEL_W];
      cfg.re   <= wr_data[POS_RE];
    end
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      iflag <= 1'b0;
    end else if (expire) begin
      iflag <= 1'b1;
    end else if (wr_en && wr_data[POS_IFLAG]) begin
      iflag <= 1'b0;
    end
  end

  // only power-on clears the cause record
  always_ff @(posedge clk) begin
    if (por_rst) begin
      rflag <= 1'b0;
    end else if (!any_rst && grace_done && cfg.re) begin
      rflag <= 1'b1;
    end else if (!any_rst && wr_en && wr_data[POS_RFLAG]) begin
      rflag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      rst_req <= 1'b0;
    end else begin
      rst_req <= grace_done && cfg.re;
    end
  end

  always_comb begin
    rd_data                        = '0;
    rd_data[POS_PSEL +: SEL_W]     = cfg.psel;
    rd_data[POS_EN]                = cfg.en;
    rd_data[POS_IE]                = cfg.ie;
    rd_data[POS_ISEL +: SEL_W]     = cfg.isel;
    rd_data[POS_IFLAG]             = iflag;
    rd_data[POS_RFLAG]             = rflag;
    rd_data[POS_RE]                = cfg.re;
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (any_rst)
    rst_req |=> !rst_req) else $error("reset request longer than one cycle"); // R6

  AST_RST_MARKS_CAUSE: assert property (@(posedge clk) disable iff (any_rst)
    rst_req |-> rflag) else $error("reset request without cause flag"); // R6

  AST_RST_NEEDS_RE: assert property (@(posedge clk) disable iff (any_rst)
    $rose(rst_req) |-> $past(cfg.re)) else $error("reset request while disabled"); // R7

  AST_IFLAG_W1C: assert property (@(posedge clk) disable iff (any_rst)
    (wr_en && wr_data[POS_IFLAG] && !expire) |=> !iflag) else $error("flag not cleared"); // R8

  AST_CAUSE_KEPT: assert property (@(posedge clk) disable iff (por_rst)
    (any_rst && rflag) |=> rflag) else $error("watchdog reset lost cause flag"); // R9

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned PRESC_LOG2 [SEL_N] = '{0, 8, 11, 16},
  parameter int unsigned BASE_LOG2   = 14,
  parameter int unsigned STEP_LOG2   = 2,
  parameter int unsigned DELAY_TICKS = 1024
) (
  input  logic        clk,
  input  logic        rst_por_n,
  input  logic        rst_wdt_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        rst_req
);

  logic     por_rst;
  logic     any_rst;
  wdt_cfg_t cfg;
  logic     iflag;
  logic     restart;
  logic     presc_tick;
  logic     expire;
  logic     grace_done;

  assign por_rst = !rst_por_n;
  assign any_rst = !rst_por_n || !rst_wdt_n;

  wdt_ctrl_reg u_reg (
    .clk        (clk),
    .por_rst    (por_rst),
    .any_rst    (any_rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .expire     (expire),
    .grace_done (grace_done),
    .cfg        (cfg),
    .iflag      (iflag),
    .restart    (restart),
    .rst_req    (rst_req),
    .rd_data    (rd_data)
  );

  wdt_prescaler #(
    .PRESC_LOG2 (PRESC_LOG2)
  ) u_presc (
    .clk        (clk),
    .rst        (any_rst),
    .run        (cfg.en),
    .tick_en    (tick_en),
    .restart    (restart),
    .psel       (cfg.psel),
    .presc_tick (presc_tick)
  );

  wdt_interval_cnt #(
    .BASE_LOG2   (BASE_LOG2),
    .STEP_LOG2   (STEP_LOG2),
    .DELAY_TICKS (DELAY_TICKS)
  ) u_cnt (
    .clk        (clk),
    .rst        (any_rst),
    .restart    (restart),
    .tick       (presc_tick),
    .isel       (cfg.isel),
    .expire     (expire),
    .grace_done (grace_done)
  );

  assign irq = iflag && cfg.ie;

  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (any_rst)
    irq |-> rd_data[POS_IFLAG]) else $error("interrupt without flag"); // R5

endmodule

// File: tb/wdt_timer_bench.sv
module wdt_timer_bench;

  localparam int unsigned B_BASE  = 4;
  localparam int unsigned B_STEP  = 1;
  localparam int unsigned B_DELAY = 8;

  localparam logic [33:0] M_ALL = {34{1'b1}};
  localparam logic [33:0] M_RST = 34'h2_0000_0000;
  localparam logic [33:0] M_IRQ = 34'h1_0000_0000;
  localparam logic [33:0] M_IF  = 34'h0_0000_0008;
  localparam logic [33:0] M_RF  = 34'h0_0000_0004;

  localparam logic [31:0] W_EN = 32'h80, W_IE = 32'h40, W_IF = 32'h08;
  localparam logic [31:0] W_RF = 32'h04, W_RE = 32'h02, W_RS = 32'h01;

  typedef struct {
    int unsigned at;
    logic [33:0] mask;
    logic [33:0] val;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_por_n = 1'b0;
  logic        rst_wdt_n = 1'b1;
  logic        tick_en = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  logic        rst_req;
  logic [33:0] obs;

  int unsigned cyc = 0;
  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  exp_t        sb[$];

  wdt_timer #(
    .PRESC_LOG2  ('{0, 1, 2, 3}),
    .BASE_LOG2   (B_BASE),
    .STEP_LOG2   (B_STEP),
    .DELAY_TICKS (B_DELAY)
  ) u_wdt_timer (
    .clk       (clk),
    .rst_por_n (rst_por_n),
    .rst_wdt_n (rst_wdt_n),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .irq       (irq),
    .rst_req   (rst_req)
  );

  assign obs = {rst_req, irq, rd_data};

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int unsigned tmo(int unsigned s);
    return 1 << (B_BASE + B_STEP * s);
  endfunction

  // monitor: 15 ns after each rising edge, pop due items and compare
  initial begin
    forever begin
      @(posedge clk);
      #15;
      while (sb.size() > 0 && sb[0].at <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        n_checks++;
        if (e.at != cyc) begin
          n_fail++;
          $display("FAIL %s: check due at cycle %0d missed, got %h expected %h",
                   e.tag, e.at, obs & e.mask, e.val);
        end else if ((obs & e.mask) != e.val) begin
          n_fail++;
          $display("FAIL %s: cycle %0d got %h expected %h", e.tag, cyc, obs & e.mask, e.val);
        end
      end
    end
  end

  task automatic want(int unsigned off, logic [33:0] m, logic [33:0] v, string tag);
    sb.push_back('{cyc + off, m, v, tag});
  endtask

  task automatic wr(logic [31:0] v);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic por();
    rst_por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_por_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, got %0d cycles expected fewer than 200000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    por();
    want(0, M_ALL, 34'h0_0000_0400, "R1 power-on value");
    drain();

    // flags and restart bit read back as 0 after a write
    wr(32'h400 | W_RF | W_IF | W_RS);
    want(0, M_ALL, 34'h0_0000_0400, "R2 restart bit reads 0");
    drain();

    // full two-stage expiry, then watchdog reset
    por();
    wr(W_EN | W_RF | W_RE | W_IF | W_IE | W_RS);
    want(0, M_ALL, 34'h0_0000_00C2, "R8 write 1 to clear flags");
    want(15, M_IF | M_IRQ, 34'h0, "R4 no flag before timeout");
    want(16, M_ALL, 34'h1_0000_00CA, "R5 flag and irq at timeout");
    want(16 + B_DELAY - 1, M_RST, 34'h0, "R6 no request early");
    want(16 + B_DELAY, M_RST | M_RF, M_RST | M_RF, "R6 request and cause flag");
    want(16 + B_DELAY + 1, M_RST, 34'h0, "R6 request lasts one cycle");
    drain();
    rst_wdt_n = 1'b0;
    @(negedge clk);
    rst_wdt_n = 1'b1;
    want(0, M_ALL, 34'h0_0000_0404, "R9 watchdog reset keeps cause");
    drain();
    por();
    want(0, M_ALL, 34'h0_0000_0400, "R9 power-on clears cause");
    drain();

    // all prescale and interval selects
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 4; s++) begin
        int unsigned n;
        n = tmo(s) * (1 << c);
        por();
        wr((32'(c) << 10) | (32'(s) << 4) | W_EN | W_IE | W_RS);
        want(n - 1, M_IF | M_IRQ, 34'h0, $sformatf("R3 R4 early psel=%0d isel=%0d", c, s));
        want(n, M_IF | M_IRQ, M_IF | M_IRQ, $sformatf("R3 R4 exact psel=%0d isel=%0d", c, s));
        drain();
      end
    end

    // neither interrupt nor reset enabled
    por();
    wr(W_EN | W_RS);
    want(16, M_IF | M_IRQ, M_IF, "R5 flag set with irq masked");
    want(16 + B_DELAY, M_RST | M_RF, 34'h0, "R7 no request");
    want(16 + B_DELAY + 2, M_RST | M_RF | M_IF, M_IF, "R7 cause flag clear");
    drain();
    wr(W_EN | W_IE);
    want(0, M_IF | M_IRQ, M_IF | M_IRQ, "R5 irq follows enable, R8 zero keeps flag");
    drain();
    wr(W_EN | W_IE | W_IF);
    want(0, M_IF | M_IRQ, 34'h0, "R8 flag cleared by 1");
    drain();

    // interrupt only
    por();
    wr(W_EN | W_IE | W_RS);
    want(16, M_IF | M_IRQ, M_IF | M_IRQ, "R5 irq with interrupt only");
    want(16 + B_DELAY, M_RST | M_RF, 34'h0, "R7 no request with interrupt only");
    want(16 + B_DELAY + 1, M_RST | M_RF, 34'h0, "R7 cause stays clear");
    drain();

    // reset only
    por();
    wr(W_EN | W_RE | W_RS);
    want(16, M_IF | M_IRQ, M_IF, "R5 no irq with reset only");
    want(16 + B_DELAY, M_RST | M_RF, M_RST | M_RF, "R6 request without interrupt enable");
    want(16 + B_DELAY + 1, M_RST, 34'h0, "R6 single cycle");
    drain();
    wr(W_EN | W_RE | W_RF);
    want(0, M_RF, 34'h0, "R8 cause flag cleared by 1");
    drain();

    // pause and resume
    por();
    wr(W_EN | W_IE | W_RS);
    repeat (7) @(negedge clk);
    wr(W_IE);
    want(0, M_ALL, 34'h0_0000_0040, "R10 paused readback");
    want(64, M_IF | M_IRQ, 34'h0, "R10 no expiry while paused");
    drain();
    wr(W_EN | W_IE);
    want(0, M_ALL, 34'h0_0000_00C0, "R10 resumed readback");
    want(7, M_IF, 34'h0, "R10 not before remaining time");
    want(8, M_IF | M_IRQ, M_IF | M_IRQ, "R10 expiry after remaining time");
    drain();

    // gaps in the reference tick
    por();
    wr(W_EN | W_IE | W_RS);
    want(25, M_IF, 34'h0, "R11 gap delays expiry");
    want(26, M_IF, M_IF, "R11 expiry after gap");
    repeat (4) @(negedge clk);
    tick_en = 1'b0;
    repeat (10) @(negedge clk);
    tick_en = 1'b1;
    drain();

    // restart clears the prescaler phase
    por();
    wr(32'h0C00 | W_EN | W_IE | W_RS);
    repeat (5) @(negedge clk);
    wr(32'h0C00 | W_EN | W_IE | W_RS);
    want(127, M_IF, 34'h0, "R2 phase cleared, not early");
    want(128, M_IF, M_IF, "R2 phase cleared, exact");
    drain();

    // restart during the grace period cancels it
    por();
    wr(W_EN | W_IE | W_RE | W_RS);
    want(16, M_IF, M_IF, "R2 first timeout");
    drain();
    @(negedge clk);
    wr(W_EN | W_IE | W_RE | W_RS);
    for (int k = 1; k < 16 + B_DELAY; k++) begin
      want(k, M_RST, 34'h0, "R2 grace cancelled");
    end
    want(16 + B_DELAY, M_RST, M_RST, "R2 new grace from restart");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule